// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block performs hardware handshaking for one serial channel. On the receive side it compares the receive FIFO fill level with two programmable thresholds. It drives the active-low ready-to-send pin with hysteresis: the pin goes to not-ready when the level climbs above the upper threshold, and it returns to ready only after the CPU has drained the FIFO below the lower threshold. When automatic control is off, the pin follows a modem-control bit written by the CPU.

On the transmit side, the active-low clear-to-send pin passes through a two-flop synchronizer. The synchronized value is sampled only when the transmitter reports a character boundary, so a character that is already leaving always finishes before a pause takes effect. The result is a permit signal that the transmitter checks before it starts the next character. The block also raises a one-cycle change flag each time the synchronized clear-to-send value toggles, which feeds the modem-status interrupt. Each direction has its own enable bit.

Top module: `fc_flow_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `rts_n` is 1, `tx_permit` is 1 and `cts_delta` is 0. The synchronizer resets to the not-clear value 1.
- R2: With `fc_en[1]`=1, a clock edge at which `rx_level` > `level_hi` sets `rts_n` to 1 from the next cycle.
- R3: With `fc_en[1]`=1, a clock edge at which `rx_level` < `level_lo` sets `rts_n` to 0 from the next cycle.
- R4: With `fc_en[1]`=1 and `level_lo` <= `rx_level` <= `level_hi`, `rts_n` keeps its previous value (hysteresis).
- R5: With `fc_en[1]`=0, `rts_n` equals the inverse of `mcr_rts`, as sampled at the previous edge. `rx_level` has no effect.
- R6: `cts_n_pin` is used only after two synchronizer flops. A pin change sampled at edge k becomes visible to the gate from edge k+2.
- R7: With `fc_en[0]`=1, an edge with `tx_boundary`=1 loads `tx_permit` with the inverse of the synchronized CTS. Synchronized 0 (clear) gives 1, and synchronized 1 gives 0.
- R8: With `fc_en[0]`=1 and `tx_boundary`=0, `tx_permit` does not change, whatever the CTS pin does.
- R9: With `fc_en[0]`=0, `tx_permit` is 1 from the next cycle.
- R10: `cts_delta` is a registered pulse that is 1 for exactly one cycle after each edge at which the synchronized CTS differs from its value one cycle earlier.
- R11: The two enables are independent. Bit 1 of `fc_en` controls RTS and bit 0 controls CTS, and either one can be on alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_en | input | 2 | Bit 1 automatic RTS, bit 0 automatic CTS |
| rx_level | input | CNT_W | Receive FIFO fill count |
| level_hi | input | CNT_W | Upper threshold (throttle above) |
| level_lo | input | CNT_W | Lower threshold (release below) |
| mcr_rts | input | 1 | CPU ready request used when automatic RTS is off (1 drives pin low) |
| cts_n_pin | input | 1 | Raw active-low clear-to-send pin |
| tx_boundary | input | 1 | Transmitter idle or character-done strobe |
| rts_n | output | 1 | Active-low ready-to-send pin |
| tx_permit | output | 1 | Transmitter may start the next character |
| cts_delta | output | 1 | One-cycle pulse when synchronized CTS toggles |

## Verification
The bench builds the block with `CNT_W`=7 and the default two synchronizer stages. That keeps sweeps from an empty FIFO up past the upper threshold and back down short, and it still reaches the equal-to-threshold cases on both sides of the hysteresis band. A behavioural model compared on every clock covers the two-edge synchronizer latency. It also covers CTS toggles that arrive between boundary strobes and toggles on back-to-back cycles, as well as mixed enable settings.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int FC_CTS_BIT = 0;
  localparam int FC_RTS_BIT = 1;
  typedef logic [1:0] fc_en_t;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int  STAGES    = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fc_rts_hyst.sv
module fc_rts_hyst #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_en,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] lo,
  input  logic             manual_ready,
  output logic             rts_n
);
  logic above, below;
  assign above = level > hi;
  assign below = level < lo;

  always_ff @(posedge clk) begin
    if (rst)           rts_n <= 1'b1;
    else if (!auto_en) rts_n <= ~manual_ready;
    else if (above)    rts_n <= 1'b1;
    else if (below)    rts_n <= 1'b0;
  end

  assert_rts_high_R2: assert property (@(posedge clk) disable iff (rst)
    (auto_en && (level > hi)) |=> rts_n);
  assert_rts_low_R3: assert property (@(posedge clk) disable iff (rst)
    (auto_en && (level < lo) && !(level > hi)) |=> !rts_n);
  assert_rts_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (auto_en && (level >= lo) && (level <= hi)) |=> $stable(rts_n));
  assert_rts_manual_R5: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> (rts_n == !$past(manual_ready)));
endmodule

// File: rtl/fc_cts_gate.sv
module fc_cts_gate (
  input  logic clk,
  input  logic rst,
  input  logic auto_en,
  input  logic cts_n_sync,
  input  logic boundary,
  output logic permit
);
  always_ff @(posedge clk) begin
    if (rst)           permit <= 1'b1;
    else if (!auto_en) permit <= 1'b1;
    else if (boundary) permit <= ~cts_n_sync;
  end

  assert_gate_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (auto_en && !boundary) |=> $stable(permit));
  assert_gate_off_R9: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> permit);
  assert_gate_load_R7: assert property (@(posedge clk) disable iff (rst)
    (auto_en && boundary) |=> (permit != $past(cts_n_sync)));
endmodule

// File: rtl/fc_flow_ctrl.sv
module fc_flow_ctrl #(
  parameter int CNT_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       fc_en,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] level_hi,
  input  logic [CNT_W-1:0] level_lo,
  input  logic             mcr_rts,
  input  logic             cts_n_pin,
  input  logic             tx_boundary,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             cts_delta
);
  import fc_pkg::*;

  fc_en_t en;
  logic   cts_s, cts_prev;
  assign en = fc_en;

  fc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(cts_n_pin), .q(cts_s));

  fc_rts_hyst #(.CNT_W(CNT_W)) u_rts (
    .clk(clk), .rst(rst), .auto_en(en[FC_RTS_BIT]), .level(rx_level),
    .hi(level_hi), .lo(level_lo), .manual_ready(mcr_rts), .rts_n(rts_n));

  fc_cts_gate u_cts (
    .clk(clk), .rst(rst), .auto_en(en[FC_CTS_BIT]), .cts_n_sync(cts_s),
    .boundary(tx_boundary), .permit(tx_permit));

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_prev  <= 1'b1;
      cts_delta <= 1'b0;
    end else begin
      cts_prev  <= cts_s;
      cts_delta <= cts_s ^ cts_prev;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (rts_n && tx_permit && !cts_delta));
  assert_delta_src_R10: assert property (@(posedge clk) disable iff (rst)
    cts_delta |-> ($past(cts_s) != $past(cts_prev)));
endmodule

// File: tb/fc_flow_ctrl_bench.sv
module fc_flow_ctrl_bench;
  localparam int W = 7;

  logic         clk = 0, rst = 1;
  logic [1:0]   fc_en = 0;
  logic [W-1:0] rx_level = 0, level_hi = 30, level_lo = 10;
  logic         mcr_rts = 0, cts_n_pin = 1, tx_boundary = 0;
  logic         rts_n, tx_permit, cts_delta;

  fc_flow_ctrl #(.CNT_W(W)) u_fc_flow_ctrl (
    .clk(clk), .rst(rst), .fc_en(fc_en), .rx_level(rx_level),
    .level_hi(level_hi), .level_lo(level_lo), .mcr_rts(mcr_rts),
    .cts_n_pin(cts_n_pin), .tx_boundary(tx_boundary), .rts_n(rts_n),
    .tx_permit(tx_permit), .cts_delta(cts_delta));

  always #10 clk = ~clk;

  int    checks = 0, errors = 0;
  string rts_req = "R1", cts_req = "R1";
  bit    done = 0;

  // behavioural reference: CTS pin history and expected outputs
  bit pin_hist[$];
  bit e_rts = 1, e_permit = 1, e_delta = 0;

  always @(posedge clk) begin
    if (rst) begin
      e_rts = 1; e_permit = 1; e_delta = 0;
      pin_hist = {1'b1, 1'b1, 1'b1};
    end else begin
      bit seen_now, seen_before;
      seen_now    = pin_hist[1];
      seen_before = pin_hist[2];
      e_delta = (seen_now != seen_before);
      if (!fc_en[0])        e_permit = 1;
      else if (tx_boundary) e_permit = !seen_now;
      if (!fc_en[1])                      e_rts = !mcr_rts;
      else if (int'(rx_level) > int'(level_hi)) e_rts = 1;
      else if (int'(rx_level) < int'(level_lo)) e_rts = 0;
      pin_hist.push_front(cts_n_pin);
      void'(pin_hist.pop_back());
    end
  end

  task automatic check(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(rts_req, "rts_n", rts_n, e_rts);
    check(cts_req, "tx_permit", tx_permit, e_permit);
    check("R10", "cts_delta", cts_delta, e_delta);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    // R1: reset values and first cycle after release
    check("R1", "rts_n reset", rts_n, 1);
    check("R1", "tx_permit reset", tx_permit, 1);
    rst = 0;
    step(1);
    check("R1", "cts_delta after reset", cts_delta, 0);

    // R5: manual RTS, level ignored
    rts_req = "R5"; cts_req = "R9";
    for (int i = 0; i < 12; i++) begin
      mcr_rts = i[0]; rx_level = W'(i * 11);
      step(1);
    end

    // R2, R3, R4: hysteresis sweep up then down, CTS off (R11)
    fc_en = 2'b10; rts_req = "R4"; cts_req = "R11";
    for (int i = 0; i <= 40; i++) begin
      rx_level = W'(i);
      rts_req = (i > 30) ? "R2" : (i < 10) ? "R3" : "R4";
      cts_n_pin = i[2];
      step(1);
    end
    for (int i = 40; i >= 0; i--) begin
      rx_level = W'(i);
      rts_req = (i > 30) ? "R2" : (i < 10) ? "R3" : "R4";
      step(1);
    end
    // R4: equal-to-threshold edges
    rx_level = 30; step(3);
    rx_level = 10; step(3);

    // R7, R6: CTS gating, RTS back to manual
    fc_en = 2'b01; rts_req = "R11"; cts_req = "R7"; mcr_rts = 1;
    for (int i = 0; i < 60; i++) begin
      cts_n_pin   = ((i / 5) % 2) == 1;
      tx_boundary = (i % 3) == 0;
      cts_req     = tx_boundary ? "R6" : "R7";
      step(1);
    end
    tx_boundary = 0;

    // R8: pin toggles, no boundary
    cts_req = "R8";
    for (int i = 0; i < 20; i++) begin
      cts_n_pin = i[0]; step(1);
    end
    cts_n_pin = 1; step(3);
    tx_boundary = 1; cts_req = "R7"; step(1);
    tx_boundary = 0; step(2);

    // R9: disable gate
    fc_en = 2'b00; cts_req = "R9"; rts_req = "R5"; step(3);

    // R11: both on with mixed stimulus
    fc_en = 2'b11; rts_req = "R11"; cts_req = "R11";
    for (int i = 0; i < 50; i++) begin
      rx_level    = W'((i * 7) % 50);
      cts_n_pin   = (i % 4) < 2;
      tx_boundary = i[0];
      step(1);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule